// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block decides whether each received Ethernet frame is kept. While a frame arrives, the first six bytes, which form the destination address, are compared one at a time against the programmed station address. The block records three facts about the address: whether every byte matched, whether every byte was all ones, and whether the group bit was set. It does not keep the address itself. When the frame ends, the receive path presents the frame length, a CRC-good flag and the 6-bit hash index of the destination. One clock later the block reports its decision.

Five receive option bits control acceptance. They cover keeping errored frames, keeping short frames, taking broadcast, taking hashed multicast, and promiscuous physical reception. The outputs are an accept pulse and a flag that tells a group acceptance apart from a physical match. Two event pulses let a remote station switch the local transmitter off or on. It does this by sending to a multicast address that hashes into either of the two top slots of the hash array.

Top module: `rx_addr_filter`

## Requirements
- R1: When `rx_cfg[0]` is 0, a frame with `crc_good` low is rejected. When `rx_cfg[0]` is 1, the CRC flag has no effect on acceptance.
- R2: When `rx_cfg[1]` is 0, a frame with `frame_len` below 64 is rejected. When `rx_cfg[1]` is 1, length has no effect on acceptance.
- R3: A destination whose six bytes are all 0xFF is a broadcast. It is accepted only when `rx_cfg[2]` is 1.
- R4: A destination whose first received byte has bit 0 set, and which is not broadcast, is a multicast. It is accepted only when `rx_cfg[3]` is 1 and `hash_array[hash_idx]` is 1. Hash slot n lives in byte register n/8 at bit n%8, which in the packed array is bit n.
- R5: A destination whose first byte has bit 0 clear is physical. It is accepted when `rx_cfg[4]` is 1, or when every byte k equals `station_addr[8k+7:8k]`. Byte 0 is the first one received.
- R6: `group_hit` is 1 with an accepted broadcast or multicast frame. It is 0 with an accepted physical frame and 0 whenever `accept` is 0.
- R7: When `atd_en` is 1, a CRC-good, non-broadcast multicast frame with `hash_idx` 62 pulses `tx_disable_evt`, and one with index 63 pulses `tx_enable_evt`. This does not depend on `rx_cfg` or the hash array contents. With `atd_en` 0, or any other index, neither event occurs.
- R8: `result_valid`, `accept`, `group_hit` and the events are valid for exactly the one clock after the cycle in which `frame_end` is high. They are 0 at all other times.
- R9: Only the first six bytes after `frame_start` form the address, and later bytes have no effect. A frame that delivered fewer than six bytes is rejected and raises no event.
- R10: During and after reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Marks the first byte of a frame; clears the address capture |
| byte_valid | input | 1 | A received byte is on `byte_data` |
| byte_data | input | 8 | Received byte |
| frame_end | input | 1 | Frame complete; length, CRC flag and hash index are valid |
| frame_len | input | 16 | Frame length in bytes |
| crc_good | input | 1 | CRC and alignment were correct |
| hash_idx | input | 6 | Hash slot of the destination address |
| station_addr | input | 48 | Station address, byte k at bits 8k+7:8k |
| hash_array | input | 64 | Multicast hash slots |
| rx_cfg | input | 5 | Option bits: keep errored, keep short, broadcast, multicast, promiscuous |
| atd_en | input | 1 | Allow remote transmitter disable/enable |
| result_valid | output | 1 | Decision is present this cycle |
| accept | output | 1 | Frame is kept |
| group_hit | output | 1 | Accepted through broadcast or multicast |
| tx_disable_evt | output | 1 | Transmitter disable request |
| tx_enable_evt | output | 1 | Transmitter enable request |

## Verification
The hardest case to reach is the address classification when the byte stream does not match a plain six-byte frame. This covers frames cut short before the sixth byte, frames whose trailing bytes would spoil a station match if they were captured, and broadcast frames whose hash index lands on a transmitter control slot. The bench drives byte counts of its own choice, including nine-byte and three-byte destinations. It pairs those streams with hash indices 61 to 63 under both settings of the transmitter-control enable. A full sweep of all 32 option settings against five address classes, two CRC states and two lengths covers the acceptance matrix. A one-hot walk over all 64 hash slots pins down the slot numbering.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   localparam int CFG_W          = 5;
   localparam int CFG_KEEP_ERR   = 0;
   localparam int CFG_KEEP_SHORT = 1;
   localparam int CFG_BCAST      = 2;
   localparam int CFG_MCAST      = 3;
   localparam int CFG_PROMISC    = 4;

   typedef struct packed {
      logic complete;   // all address bytes seen
      logic stn_match;  // every byte equal to station address
      logic all_ones;   // every byte 0xFF
      logic group;      // group bit of first byte
   } addr_flags_t;
endpackage

// File: rtl/rxf_addr_capture.sv
module rxf_addr_capture
   import rxf_pkg::*;
#(
   parameter int ADDR_BYTES = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    frame_start,
   input  logic                    byte_valid,
   input  logic [7:0]              byte_data,
   input  logic [8*ADDR_BYTES-1:0] station_addr,
   output addr_flags_t             flags
);
   localparam int CNT_W = $clog2(ADDR_BYTES + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(ADDR_BYTES);

   logic [CNT_W-1:0]      cnt_q;
   logic [CNT_W-1:0]      idx;
   logic [ADDR_BYTES-1:0] eq_q, ff_q, byte_eq;
   logic                  grp_q;

   assign idx = frame_start ? '0 : cnt_q;

   for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_cmp
      assign byte_eq[k] = (byte_data == station_addr[8*k +: 8]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         eq_q  <= '0;
         ff_q  <= '0;
         grp_q <= 1'b0;
      end else begin
         if (frame_start) begin
            cnt_q <= '0;
            eq_q  <= '0;
            ff_q  <= '0;
            grp_q <= 1'b0;
         end
         if (byte_valid && (idx < FULL)) begin
            cnt_q     <= idx + CNT_W'(1);
            eq_q[idx] <= byte_eq[idx];
            ff_q[idx] <= (byte_data == 8'hFF);
            if (idx == '0) grp_q <= byte_data[0];
         end
      end
   end

   assign flags.complete  = (cnt_q == FULL);
   assign flags.stn_match = &eq_q;
   assign flags.all_ones  = &ff_q;
   assign flags.group     = grp_q;
endmodule

// File: rtl/rxf_hash_select.sv
module rxf_hash_select #(
   parameter int HASH_BITS = 64,
   localparam int HIDX_W   = $clog2(HASH_BITS)
) (
   input  logic [HASH_BITS-1:0] hash_array,
   input  logic [HIDX_W-1:0]    hash_idx,
   output logic                 hit,
   output logic                 dis_slot,
   output logic                 en_slot
);
   localparam int NREG = HASH_BITS / 8;
   localparam logic [HIDX_W-1:0] DIS_IDX = HIDX_W'(HASH_BITS - 2);
   localparam logic [HIDX_W-1:0] EN_IDX  = HIDX_W'(HASH_BITS - 1);

   // register bank view: upper index bits pick the byte, lower three the bit
   logic [7:0] bank [NREG];
   for (genvar r = 0; r < NREG; r++) begin : g_bank
      assign bank[r] = hash_array[8*r +: 8];
   end

   if (NREG > 1) begin : g_multi
      assign hit = bank[hash_idx[HIDX_W-1:3]][hash_idx[2:0]];
   end else begin : g_single
      assign hit = bank[0][hash_idx[2:0]];
   end

   assign dis_slot = (hash_idx == DIS_IDX);
   assign en_slot  = (hash_idx == EN_IDX);
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
   import rxf_pkg::*;
#(
   parameter int LEN_W   = 16,
   parameter int MIN_LEN = 64
) (
   input  addr_flags_t      flags,
   input  logic             hash_hit,
   input  logic             dis_slot,
   input  logic             en_slot,
   input  logic             crc_good,
   input  logic [LEN_W-1:0] frame_len,
   input  logic [CFG_W-1:0] rx_cfg,
   input  logic             atd_en,
   output logic             accept_c,
   output logic             group_c,
   output logic             dis_c,
   output logic             en_c
);
   logic is_bcast, is_mcast, is_phys, addr_ok, err_ok, len_ok, atd_ok;

   always_comb begin
      is_bcast = flags.all_ones;
      is_mcast = flags.group && !flags.all_ones;
      is_phys  = !flags.group;
      addr_ok  = (is_phys  && (rx_cfg[CFG_PROMISC] || flags.stn_match)) ||
                 (is_bcast && rx_cfg[CFG_BCAST]) ||
                 (is_mcast && rx_cfg[CFG_MCAST] && hash_hit);
      err_ok   = crc_good || rx_cfg[CFG_KEEP_ERR];
      len_ok   = (frame_len >= LEN_W'(MIN_LEN)) || rx_cfg[CFG_KEEP_SHORT];
      accept_c = flags.complete && addr_ok && err_ok && len_ok;
      group_c  = accept_c && !is_phys;
      atd_ok   = atd_en && flags.complete && is_mcast && crc_good;
      dis_c    = atd_ok && dis_slot;
      en_c     = atd_ok && en_slot;
   end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import rxf_pkg::*;
#(
   parameter int ADDR_BYTES = 6,
   parameter int HASH_BITS  = 64,
   parameter int LEN_W      = 16,
   parameter int MIN_LEN    = 64,
   localparam int HIDX_W    = $clog2(HASH_BITS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    frame_start,
   input  logic                    byte_valid,
   input  logic [7:0]              byte_data,
   input  logic                    frame_end,
   input  logic [LEN_W-1:0]        frame_len,
   input  logic                    crc_good,
   input  logic [HIDX_W-1:0]       hash_idx,
   input  logic [8*ADDR_BYTES-1:0] station_addr,
   input  logic [HASH_BITS-1:0]    hash_array,
   input  logic [CFG_W-1:0]        rx_cfg,
   input  logic                    atd_en,
   output logic                    result_valid,
   output logic                    accept,
   output logic                    group_hit,
   output logic                    tx_disable_evt,
   output logic                    tx_enable_evt
);
   if (ADDR_BYTES < 1) begin : g_bad_addr
      $error("ADDR_BYTES must be at least 1");
   end
   if ((HASH_BITS < 8) || (HASH_BITS % 8 != 0) || ((1 << HIDX_W) != HASH_BITS)) begin : g_bad_hash
      $error("HASH_BITS must be a power of two and at least 8");
   end
   if (MIN_LEN >= (1 << LEN_W)) begin : g_bad_len
      $error("MIN_LEN must fit in LEN_W bits");
   end

   addr_flags_t flags;
   logic hash_hit, dis_slot, en_slot;
   logic accept_c, group_c, dis_c, en_c;

   rxf_addr_capture #(.ADDR_BYTES(ADDR_BYTES)) u_cap (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_start  (frame_start),
      .byte_valid   (byte_valid),
      .byte_data    (byte_data),
      .station_addr (station_addr),
      .flags        (flags)
   );

   rxf_hash_select #(.HASH_BITS(HASH_BITS)) u_hash (
      .hash_array (hash_array),
      .hash_idx   (hash_idx),
      .hit        (hash_hit),
      .dis_slot   (dis_slot),
      .en_slot    (en_slot)
   );

   rxf_decide #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_dec (
      .flags     (flags),
      .hash_hit  (hash_hit),
      .dis_slot  (dis_slot),
      .en_slot   (en_slot),
      .crc_good  (crc_good),
      .frame_len (frame_len),
      .rx_cfg    (rx_cfg),
      .atd_en    (atd_en),
      .accept_c  (accept_c),
      .group_c   (group_c),
      .dis_c     (dis_c),
      .en_c      (en_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_valid   <= 1'b0;
         accept         <= 1'b0;
         group_hit      <= 1'b0;
         tx_disable_evt <= 1'b0;
         tx_enable_evt  <= 1'b0;
      end else begin
         result_valid   <= frame_end;
         accept         <= frame_end && accept_c;
         group_hit      <= frame_end && group_c;
         tx_disable_evt <= frame_end && dis_c;
         tx_enable_evt  <= frame_end && en_c;
      end
   end
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
   parameter int LEN_W   = 16,
   parameter int MIN_LEN = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_end,
   input logic [LEN_W-1:0] frame_len,
   input logic             crc_good,
   input logic [4:0]       rx_cfg,
   input logic             atd_en,
   input logic             result_valid,
   input logic             accept,
   input logic             group_hit,
   input logic             tx_disable_evt,
   input logic             tx_enable_evt
);
   assert_end_gives_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> result_valid);
   assert_result_after_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> $past(frame_end));
   assert_accept_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (accept || tx_disable_evt || tx_enable_evt) |-> result_valid);
   assert_group_needs_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      group_hit |-> accept);
   assert_err_dropped_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !$past(rx_cfg[0])) |-> $past(crc_good));
   assert_short_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !$past(rx_cfg[1])) |-> ($past(frame_len) >= LEN_W'(MIN_LEN)));
   assert_events_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_disable_evt && tx_enable_evt));
   assert_events_need_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_disable_evt || tx_enable_evt) |-> ($past(atd_en) && $past(crc_good)));
endmodule

bind rx_addr_filter rxf_checker #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .frame_end      (frame_end),
   .frame_len      (frame_len),
   .crc_good       (crc_good),
   .rx_cfg         (rx_cfg),
   .atd_en         (atd_en),
   .result_valid   (result_valid),
   .accept         (accept),
   .group_hit      (group_hit),
   .tx_disable_evt (tx_disable_evt),
   .tx_enable_evt  (tx_enable_evt)
);

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_start = 1'b0, byte_valid = 1'b0, frame_end = 1'b0;
   logic [7:0]  byte_data = '0;
   logic [15:0] frame_len = '0;
   logic        crc_good = 1'b0;
   logic [5:0]  hash_idx = '0;
   logic [47:0] station_addr = 48'h665544332210;
   logic [63:0] hash_array = 64'hA5C3_0F96_1234_8E71;
   logic [4:0]  rx_cfg = '0;
   logic        atd_en = 1'b0;
   logic        result_valid, accept, group_hit, tx_disable_evt, tx_enable_evt;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   logic o_valid, o_acc, o_grp, o_dis, o_en;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_addr_filter u0 (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byte_valid(byte_valid),
      .byte_data(byte_data), .frame_end(frame_end), .frame_len(frame_len),
      .crc_good(crc_good), .hash_idx(hash_idx), .station_addr(station_addr),
      .hash_array(hash_array), .rx_cfg(rx_cfg), .atd_en(atd_en),
      .result_valid(result_valid), .accept(accept), .group_hit(group_hit),
      .tx_disable_evt(tx_disable_evt), .tx_enable_evt(tx_enable_evt)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
      end
   endtask

   // sends nb bytes of dst, then frame_end; leaves outputs captured in o_*
   task automatic run_frame(input logic [71:0] dst, input int nb, input int len,
                            input logic crc, input int hidx);
      @(negedge clk);
      frame_start = 1'b1; byte_valid = 1'b1; byte_data = dst[7:0];
      for (int k = 1; k < nb; k++) begin
         @(negedge clk);
         frame_start = 1'b0; byte_data = dst[8*k +: 8];
      end
      @(negedge clk);
      frame_start = 1'b0; byte_valid = 1'b0;
      frame_end = 1'b1; frame_len = 16'(len); crc_good = crc; hash_idx = 6'(hidx);
      chk("R8", "valid before decision", result_valid, 1'b0);
      @(negedge clk);
      frame_end = 1'b0;
      o_valid = result_valid; o_acc = accept; o_grp = group_hit;
      o_dis = tx_disable_evt; o_en = tx_enable_evt;
      chk("R8", "valid one clock after end", o_valid, 1'b1);
      @(negedge clk);
      chk("R8", "accept returns low", accept, 1'b0);
   endtask

   function automatic logic [71:0] class_addr(input int c);
      case (c)
         0: return {24'h0, 48'h665544332210};    // station
         1: return {24'h0, 48'h665544332610};    // other physical
         2: return {24'h0, 48'hFFFFFFFFFFFF};    // broadcast
         default: return {24'h0, 48'h0000005E0001}; // multicast
      endcase
   endfunction

   initial begin
      int hit_idx, miss_idx;
      repeat (3) @(negedge clk);
      chk("R10", "valid in reset", result_valid, 1'b0);
      chk("R10", "accept in reset", accept, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "valid after reset", result_valid, 1'b0);
      chk("R10", "events after reset", tx_disable_evt | tx_enable_evt | group_hit, 1'b0);

      hit_idx = 0; miss_idx = 1;
      for (int n = 0; n < 64; n++) if (hash_array[n]) hit_idx = n;
      for (int n = 0; n < 64; n++) if (!hash_array[n]) miss_idx = n;

      // R1..R6 sweep: all options x address class x CRC x length
      for (int cfg = 0; cfg < 32; cfg++) begin
         for (int c = 0; c < 5; c++) begin
            for (int e = 0; e < 2; e++) begin
               for (int s = 0; s < 2; s++) begin
                  logic phys, aok, exp_acc;
                  int hx, ln;
                  hx = (c == 4) ? miss_idx : hit_idx;
                  ln = s ? 63 : 64;
                  rx_cfg = 5'(cfg);
                  phys = (c < 2);
                  case (c)
                     0: aok = 1'b1;
                     1: aok = rx_cfg[4];
                     2: aok = rx_cfg[2];
                     3: aok = rx_cfg[3];
                     default: aok = 1'b0;
                  endcase
                  if (c == 0) aok = 1'b1;
                  exp_acc = aok && (e == 0 || rx_cfg[0]) && (s == 0 || rx_cfg[1]);
                  run_frame(class_addr(c), 6, ln, (e == 0), hx);
                  if (e == 1) chk("R1", "crc option", o_acc, exp_acc);
                  else if (s == 1) chk("R2", "short option", o_acc, exp_acc);
                  else if (c == 2) chk("R3", "broadcast", o_acc, exp_acc);
                  else if (c >= 3) chk("R4", "multicast", o_acc, exp_acc);
                  else chk("R5", "physical", o_acc, exp_acc);
                  chk("R6", "group flag", o_grp, exp_acc && !phys);
                  chk("R7", "no events without enable", o_dis | o_en, 1'b0);
               end
            end
         end
      end

      // R4 slot numbering: one-hot walk
      rx_cfg = 5'b01000;
      for (int n = 0; n < 64; n++) begin
         hash_array = 64'd1 << n;
         run_frame(class_addr(3), 6, 100, 1'b1, n);
         chk("R4", "one-hot slot hit", o_acc, 1'b1);
         run_frame(class_addr(3), 6, 100, 1'b1, (n + 1) % 64);
         chk("R4", "neighbour slot miss", o_acc, 1'b0);
      end
      hash_array = 64'h0;

      // R7 transmitter control
      rx_cfg = 5'b00000;
      for (int a = 0; a < 2; a++) begin
         for (int ix = 61; ix < 64; ix++) begin
            for (int e = 0; e < 2; e++) begin
               atd_en = a[0];
               run_frame(class_addr(3), 6, 100, (e == 0), ix);
               chk("R7", "disable event", o_dis, a[0] && e == 0 && ix == 62);
               chk("R7", "enable event", o_en, a[0] && e == 0 && ix == 63);
            end
         end
      end
      atd_en = 1'b1;
      run_frame(class_addr(2), 6, 100, 1'b1, 62);
      chk("R7", "broadcast raises no disable", o_dis, 1'b0);
      run_frame(class_addr(0), 6, 100, 1'b1, 63);
      chk("R7", "physical raises no enable", o_en, 1'b0);

      // R9 byte count handling
      rx_cfg = 5'b00000;
      run_frame({24'hABCDEF, 48'h665544332210}, 9, 100, 1'b1, 0);
      chk("R9", "extra bytes ignored", o_acc, 1'b1);
      rx_cfg = 5'b11111;
      run_frame({24'h0, 48'h665544332210}, 3, 100, 1'b1, 0);
      chk("R9", "short address rejected", o_acc, 1'b0);
      run_frame({24'h0, 48'h0000005E0001}, 3, 100, 1'b1, 62);
      chk("R9", "short address no event", o_dis, 1'b0);
      rx_cfg = 5'b00000;
      atd_en = 1'b0;
      run_frame({24'h0, 48'h665544332210}, 6, 100, 1'b1, 0);
      chk("R9", "capture restarts on next frame", o_acc, 1'b1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule